// File: doc/BRIEF.md
# Flash Bulk-Erase Sequencer

This block runs the closed-loop bulk-erase procedure for a byte-wide, command-driven flash array from the host side. One `start` pulse begins the sequence. First every location is brought to 00h: the block asks an external byte programmer for each address in turn over a request/acknowledge handshake. It then alternates erase pulses with verify passes that check one address at a time, and finishes by raising `done` or `fail`.

Each erase pulse is two writes of the erase command, followed by a timed wait. Each verify step writes the verify command with the target address, waits for the margin voltages to settle, and then reads the byte back. Every wait is counted in ticks of a one-cycle `us_tick` input, with lengths set by parameters.

When an address fails to verify, the block applies one more erase pulse and carries on checking from that same address. It does not go back to address zero. The total number of erase pulses in one sequence is capped by a parameter, and the count used is visible on `pulse_count`.

Top module: `erase_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `vpp_en`, `prog_req` and `pulse_count` are 0, and `ce_n`, `we_n` and `oe_n` are 1. A `start` pulse while idle raises `busy` at the next clock edge and clears `done`, `fail` and `pulse_count`. A `start` pulse while busy has no effect on the sequence or its results.
- R2: Before the first erase command is written, `prog_req` is raised for every address 0 to 2^ADDR_W-1 in ascending order. `prog_addr` holds each address until one `prog_ack` pulse is received for it.
- R3: An erase pulse is two write cycles of command byte 20h. `pulse_count` increases by one at the end of the second write. The block then waits ERASE_US ticks before its next bus cycle.
- R4: A verify step writes command byte A0h with the address under test on `mem_addr`. The block waits VERIFY_US ticks before lowering `oe_n` to read that address.
- R5: An address passes only if it reads FFh. A pass moves verification to the next address. A pass at the last address ends the sequence with `done`.
- R6: A read other than FFh, with fewer than MAX_PULSES pulses used, causes a new erase pulse, and verification resumes at the same address. Verify addresses never decrease within a sequence, and a sequence whose largest per-address need is P uses P pulses and 2^ADDR_W+P-1 verify commands.
- R7: If an address fails when `pulse_count` equals MAX_PULSES, the sequence ends with `fail` and no further erase pulse is issued.
- R8: `busy` falls on the same clock edge that `done` or `fail` rises. `done` and `fail` are never both set. They, and `pulse_count`, hold their values until the next accepted `start`.
- R9: A write cycle is one clock with `we_n` low, then one clock with `we_n` high, with `ce_n` low and data driven on `mem_dq` throughout. A read cycle holds `oe_n` low for two clocks with `mem_dq` released. `we_n` and `oe_n` are never low together, and `ce_n` is high when the block is idle.
- R10: `vpp_en` is high for the whole of a sequence, and no write strobe occurs while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an erase sequence (one-cycle pulse) |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| prog_req | output | 1 | Request to pre-program `prog_addr` to 00h |
| prog_addr | output | ADDR_W | Address to pre-program |
| prog_ack | input | 1 | Byte programmer finished the requested address |
| ce_n | output | 1 | Memory chip enable, active low |
| we_n | output | 1 | Memory write strobe, active low |
| oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq | inout | 8 | Memory data bus |
| vpp_en | output | 1 | High-voltage supply enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Array verified fully erased |
| fail | output | 1 | Pulse limit reached before the array verified |
| pulse_count | output | $clog2(MAX_PULSES+1) | Erase pulses used in the current or last sequence |

## Verification
A `start` pulse shows up on `busy` at the next edge, so the bench samples it on the falling edge that follows. The final `done`, `fail` and `pulse_count` values are due on the very edge where `busy` drops, and the bench polls each falling edge and judges them on the first one where `busy` is low. Wait lengths are counted from the rising edge of `we_n` to the next `we_n` or `oe_n` strobe. Because the write's second clock and the idle clock before the next bus cycle may each hold a tick, the count must fall between the parameter value and that value plus two. Pulse, verify and pre-program totals come from a bench memory model and are compared with a bench function that walks the resume-at-failure rule.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PREPROG,
    SQ_ERS_SETUP,
    SQ_ERS_GO,
    SQ_ERS_WAIT,
    SQ_VFY_CMD,
    SQ_VFY_WAIT,
    SQ_VFY_READ
  } seq_state_e;

  typedef enum logic [2:0] {
    BC_IDLE,
    BC_WR_LOW,
    BC_WR_HIGH,
    BC_RD_A,
    BC_RD_B
  } bus_state_e;

  localparam logic [7:0] CMD_ERASE     = 8'h20;
  localparam logic [7:0] CMD_ERASE_VFY = 8'hA0;
  localparam logic [7:0] BYTE_BLANK    = 8'hFF;

endpackage

// File: rtl/erase_seq_timer.sv
module erase_seq_timer #(
  parameter int TMR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMR_W-1:0] len,
  input  logic             tick,
  output logic             expire
);

  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] cnt_d;
  logic             cnt_en;

  // counter restarts from zero whenever the wait state is left
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (tick) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + TMR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire = run && tick && (cnt_q == (len - TMR_W'(1)));

endmodule

// File: rtl/erase_seq_bus.sv
module erase_seq_bus
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic              rd_go,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [7:0]        wdata_in,
  output logic              bus_idle,
  output logic              op_done,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] addr_out,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);

  bus_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              cap_en;

  always_comb begin
    st_d   = st_q;
    cap_en = 1'b0;
    unique case (st_q)
      BC_IDLE: begin
        if (wr_go) begin
          st_d   = BC_WR_LOW;
          cap_en = 1'b1;
        end else if (rd_go) begin
          st_d   = BC_RD_A;
          cap_en = 1'b1;
        end
      end
      BC_WR_LOW:  st_d = BC_WR_HIGH;
      BC_WR_HIGH: st_d = BC_IDLE;
      BC_RD_A:    st_d = BC_RD_B;
      BC_RD_B:    st_d = BC_IDLE;
      default:    st_d = BC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= BC_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      addr_q <= addr_in;
      data_q <= wdata_in;
    end
  end

  assign bus_idle = (st_q == BC_IDLE);
  assign op_done  = (st_q == BC_WR_HIGH) || (st_q == BC_RD_B);
  assign ce_n     = (st_q == BC_IDLE);
  assign we_n     = (st_q != BC_WR_LOW);
  assign oe_n     = !((st_q == BC_RD_A) || (st_q == BC_RD_B));
  assign dq_oe    = (st_q == BC_WR_LOW) || (st_q == BC_WR_HIGH);
  assign addr_out = addr_q;
  assign dq_out   = data_q;

endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int MAX_PULSES = 1000,
  parameter int ERASE_US   = 10000,
  parameter int VERIFY_US  = 6,
  parameter int CNT_W      = 10,
  parameter int TMR_W      = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              prog_ack,
  input  logic              bus_idle,
  input  logic              op_done,
  input  logic [7:0]        rdata,
  input  logic              tmr_expire,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic              wr_go,
  output logic              rd_go,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  output logic              tmr_run,
  output logic [TMR_W-1:0]  tmr_len,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [CNT_W-1:0]  pulse_count
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [CNT_W-1:0]  PULSE_CAP = CNT_W'(MAX_PULSES);

  seq_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  pcnt_q, pcnt_d;
  logic              done_q, done_d;
  logic              fail_q, fail_d;
  logic              addr_en, pcnt_en, flag_en;

  always_comb begin
    st_d     = st_q;
    addr_d   = addr_q;
    pcnt_d   = pcnt_q;
    done_d   = done_q;
    fail_d   = fail_q;
    addr_en  = 1'b0;
    pcnt_en  = 1'b0;
    flag_en  = 1'b0;
    wr_go    = 1'b0;
    rd_go    = 1'b0;
    cmd_data = CMD_ERASE;
    tmr_run  = 1'b0;
    tmr_len  = TMR_W'(ERASE_US);
    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d    = SQ_PREPROG;
          addr_d  = '0;
          pcnt_d  = '0;
          done_d  = 1'b0;
          fail_d  = 1'b0;
          addr_en = 1'b1;
          pcnt_en = 1'b1;
          flag_en = 1'b1;
        end
      end
      SQ_PREPROG: begin
        if (prog_ack) begin
          addr_en = 1'b1;
          if (addr_q == LAST_ADDR) begin
            addr_d = '0;
            st_d   = SQ_ERS_SETUP;
          end else begin
            addr_d = addr_q + ADDR_W'(1);
          end
        end
      end
      SQ_ERS_SETUP: begin
        wr_go = bus_idle;
        if (op_done) st_d = SQ_ERS_GO;
      end
      SQ_ERS_GO: begin
        wr_go = bus_idle;
        if (op_done) begin
          pcnt_d  = pcnt_q + CNT_W'(1);
          pcnt_en = 1'b1;
          st_d    = SQ_ERS_WAIT;
        end
      end
      SQ_ERS_WAIT: begin
        tmr_run = 1'b1;
        if (tmr_expire) st_d = SQ_VFY_CMD;
      end
      SQ_VFY_CMD: begin
        wr_go    = bus_idle;
        cmd_data = CMD_ERASE_VFY;
        if (op_done) st_d = SQ_VFY_WAIT;
      end
      SQ_VFY_WAIT: begin
        tmr_run = 1'b1;
        tmr_len = TMR_W'(VERIFY_US);
        if (tmr_expire) st_d = SQ_VFY_READ;
      end
      SQ_VFY_READ: begin
        rd_go = bus_idle;
        if (op_done) begin
          if (rdata == BYTE_BLANK) begin
            if (addr_q == LAST_ADDR) begin
              done_d  = 1'b1;
              flag_en = 1'b1;
              st_d    = SQ_IDLE;
            end else begin
              addr_d  = addr_q + ADDR_W'(1);
              addr_en = 1'b1;
              st_d    = SQ_VFY_CMD;
            end
          end else if (pcnt_q == PULSE_CAP) begin
            fail_d  = 1'b1;
            flag_en = 1'b1;
            st_d    = SQ_IDLE;
          end else begin
            // address is kept: checking resumes where it failed
            st_d = SQ_ERS_SETUP;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (pcnt_en) begin
      pcnt_q <= pcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (flag_en) begin
      done_q <= done_d;
      fail_q <= fail_d;
    end
  end

  assign prog_req    = (st_q == SQ_PREPROG);
  assign prog_addr   = addr_q;
  assign cmd_addr    = addr_q;
  assign busy        = (st_q != SQ_IDLE);
  assign done        = done_q;
  assign fail        = fail_q;
  assign pulse_count = pcnt_q;

endmodule

// File: rtl/erase_seq.sv
module erase_seq #(
  parameter int  ADDR_W     = 16,
  parameter int  MAX_PULSES = 1000,
  parameter int  ERASE_US   = 10000,
  parameter int  VERIFY_US  = 6,
  localparam int CNT_W      = $clog2(MAX_PULSES + 1),
  localparam int TMR_W      = $clog2(((ERASE_US > VERIFY_US) ? ERASE_US : VERIFY_US) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              us_tick,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  input  logic              prog_ack,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [7:0]        mem_dq,
  output logic              vpp_en,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [CNT_W-1:0]  pulse_count
);

  logic              wr_go, rd_go, bus_idle, op_done;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        cmd_data, dq_out, rdata;
  logic              dq_oe;
  logic              tmr_run, tmr_expire;
  logic [TMR_W-1:0]  tmr_len;

  erase_seq_ctrl #(
    .ADDR_W    (ADDR_W),
    .MAX_PULSES(MAX_PULSES),
    .ERASE_US  (ERASE_US),
    .VERIFY_US (VERIFY_US),
    .CNT_W     (CNT_W),
    .TMR_W     (TMR_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .prog_ack   (prog_ack),
    .bus_idle   (bus_idle),
    .op_done    (op_done),
    .rdata      (rdata),
    .tmr_expire (tmr_expire),
    .prog_req   (prog_req),
    .prog_addr  (prog_addr),
    .wr_go      (wr_go),
    .rd_go      (rd_go),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .tmr_run    (tmr_run),
    .tmr_len    (tmr_len),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .pulse_count(pulse_count)
  );

  erase_seq_bus #(
    .ADDR_W(ADDR_W)
  ) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_go   (wr_go),
    .rd_go   (rd_go),
    .addr_in (cmd_addr),
    .wdata_in(cmd_data),
    .bus_idle(bus_idle),
    .op_done (op_done),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .addr_out(mem_addr),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe)
  );

  erase_seq_timer #(
    .TMR_W(TMR_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (tmr_run),
    .len   (tmr_len),
    .tick  (us_tick),
    .expire(tmr_expire)
  );

  assign mem_dq = dq_oe ? dq_out : 8'bz;
  assign rdata  = mem_dq;
  assign vpp_en = busy;

endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
  parameter int MAX_PULSES = 1000,
  parameter int CNT_W      = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_n,
  input logic             we_n,
  input logic             oe_n,
  input logic             dq_oe,
  input logic             prog_req,
  input logic             vpp_en,
  input logic             busy,
  input logic             done,
  input logic             fail,
  input logic [CNT_W-1:0] pulse_count
);

  a_r9_no_strobe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));

  a_r9_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);

  a_r9_release_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);

  a_r9_ce_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ce_n);

  a_r8_exclusive_end: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  a_r8_busy_ends_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || fail));

  a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy);

  a_r7_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_count <= CNT_W'(MAX_PULSES));

  a_r3_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (pulse_count >= $past(pulse_count)));

  a_r2_req_in_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> busy);

  a_r10_write_needs_vpp: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> vpp_en);

endmodule

bind erase_seq erase_seq_chk #(
  .MAX_PULSES(MAX_PULSES),
  .CNT_W     (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_n       (ce_n),
  .we_n       (we_n),
  .oe_n       (oe_n),
  .dq_oe      (dq_oe),
  .prog_req   (prog_req),
  .vpp_en     (vpp_en),
  .busy       (busy),
  .done       (done),
  .fail       (fail),
  .pulse_count(pulse_count)
);

// File: tb/erase_seq_bench.sv
module erase_seq_bench;

  localparam int ADDR_W = 3;
  localparam int NADDR  = 1 << ADDR_W;
  localparam int MAXP   = 6;
  localparam int ERS_US = 3;
  localparam int VFY_US = 2;
  localparam int CNT_W  = $clog2(MAXP + 1);

  logic              clk, rst_n, start, us_tick, prog_ack;
  logic              prog_req, ce_n, we_n, oe_n, vpp_en, busy, done, fail;
  logic [ADDR_W-1:0] prog_addr, mem_addr;
  logic [CNT_W-1:0]  pulse_count;
  wire  [7:0]        mem_dq;

  erase_seq #(
    .ADDR_W(ADDR_W), .MAX_PULSES(MAXP), .ERASE_US(ERS_US), .VERIFY_US(VFY_US)
  ) u_erase_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .us_tick(us_tick),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_ack(prog_ack),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .mem_addr(mem_addr), .mem_dq(mem_dq),
    .vpp_en(vpp_en), .busy(busy), .done(done), .fail(fail), .pulse_count(pulse_count)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  // one tick every four clocks
  initial begin
    int div;
    div = 0;
    us_tick = 1'b0;
    forever begin
      @(posedge clk);
      div = (div + 1) % 4;
      us_tick <= (div == 0);
    end
  end

  // ---------------- memory model ----------------
  int                need [NADDR];
  int                pulses, verifies, pp_cnt, pp_order_err, decrease_err, early_err;
  int                vaddr_prev;
  logic [7:0]        last_cmd;
  logic [ADDR_W-1:0] lat_addr;

  always @(negedge we_n) if (ce_n === 1'b0) lat_addr = mem_addr;

  always @(posedge we_n) begin
    if (ce_n === 1'b0) begin
      if (mem_dq == 8'h20 && last_cmd == 8'h20) begin
        pulses++;
        if (pp_cnt != NADDR) early_err++;
        last_cmd = 8'h00;
      end else begin
        last_cmd = mem_dq;
      end
      if (mem_dq == 8'hA0) begin
        verifies++;
        if (int'(lat_addr) < vaddr_prev) decrease_err++;
        vaddr_prev = int'(lat_addr);
      end
    end
  end

  assign mem_dq = (ce_n === 1'b0 && oe_n === 1'b0)
                  ? ((pulses >= need[lat_addr]) ? 8'hFF : 8'h00) : 8'bz;

  // byte-programmer responder
  initial begin
    prog_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && prog_req) begin
        repeat ($urandom % 3) @(negedge clk);
        if (int'(prog_addr) != pp_cnt) pp_order_err++;
        pp_cnt++;
        prog_ack = 1'b1;
        @(negedge clk);
        prog_ack = 1'b0;
      end
    end
  end

  // ---------------- bus and wait-window monitor ----------------
  int   tickcnt, mark, wkind;
  bit   erase_half;
  logic we_p, oe_p;

  initial begin
    tickcnt = 0; mark = 0; wkind = 0; erase_half = 0; we_p = 1'b1; oe_p = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (we_p && !we_n && wkind == 1) begin
          chk((tickcnt - mark) >= ERS_US && (tickcnt - mark) <= ERS_US + 2,
              "R3", "erase wait ticks", tickcnt - mark, ERS_US);
          wkind = 0;
        end
        if (oe_p && !oe_n && wkind == 2) begin
          chk((tickcnt - mark) >= VFY_US && (tickcnt - mark) <= VFY_US + 2,
              "R4", "verify settle ticks", tickcnt - mark, VFY_US);
          wkind = 0;
        end
        if (!we_p && we_n) begin
          mark = tickcnt;
          if (mem_dq == 8'h20) begin
            if (erase_half) begin wkind = 1; erase_half = 0; end
            else erase_half = 1;
          end else if (mem_dq == 8'hA0) begin
            wkind = 2;
          end
        end
        if (!we_n)
          chk(ce_n == 1'b0 && !$isunknown(mem_dq) && vpp_en, "R9",
              "write strobe with ce low, data driven, vpp on", int'(ce_n), 0);
        if (!oe_n)
          chk(ce_n == 1'b0 && we_n == 1'b1, "R9", "read strobe framing",
              int'(we_n), 1);
        if (us_tick) tickcnt++;
      end
      we_p = we_n;
      oe_p = oe_n;
    end
  end

  // ---------------- expectation from the requirements ----------------
  function automatic void predict(output bit ok, output int p, output int v);
    p = 1; v = 0; ok = 1'b1;
    for (int a = 0; a < NADDR; a++) begin
      while (1) begin
        v++;
        if (p >= need[a]) break;
        if (p == MAXP) begin ok = 1'b0; return; end
        p++;
      end
    end
  endfunction

  task automatic run_case(input string name, input bit poke);
    bit exp_ok;
    int exp_p, exp_v, waited;
    predict(exp_ok, exp_p, exp_v);
    pulses = 0; verifies = 0; pp_cnt = 0; pp_order_err = 0;
    decrease_err = 0; early_err = 0; vaddr_prev = 0; last_cmd = 8'h00;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && !fail && pulse_count == 0, "R1",
        {name, " start accepted and results cleared"}, int'(busy), 1);
    chk(vpp_en == 1'b1, "R10", {name, " vpp on while busy"}, int'(vpp_en), 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (busy && waited < 30000) begin
      @(negedge clk);
      waited++;
    end
    chk(!busy, "R8", {name, " sequence ends"}, int'(busy), 0);
    chk(done == exp_ok && fail == !exp_ok, "R8",
        {name, " done/fail on the edge busy falls"}, int'(done), int'(exp_ok));
    chk(int'(pulse_count) == exp_p && pulses == exp_p, exp_ok ? "R6" : "R7",
        {name, " pulses used"}, int'(pulse_count), exp_p);
    chk(verifies == exp_v, exp_ok ? "R5" : "R7", {name, " verify commands"},
        verifies, exp_v);
    chk(pp_cnt == NADDR && pp_order_err == 0 && early_err == 0, "R2",
        {name, " pre-program all addresses in order first"}, pp_cnt, NADDR);
    chk(decrease_err == 0, "R6", {name, " verify resumes, never rewinds"},
        decrease_err, 0);
    chk(vpp_en == 1'b0 && ce_n == 1'b1, "R10", {name, " vpp off when idle"},
        int'(vpp_en), 0);
    repeat (5) @(negedge clk);
    chk(done == exp_ok && fail == !exp_ok && int'(pulse_count) == exp_p, "R8",
        {name, " results held"}, int'(pulse_count), exp_p);
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0;
    start = 1'b0;
    for (int a = 0; a < NADDR; a++) need[a] = 1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !vpp_en && !prog_req && pulse_count == 0,
        "R1", "reset outputs low", int'(busy), 0);
    chk(ce_n && we_n && oe_n, "R1", "reset strobes high", int'(ce_n), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // single pulse suffices everywhere
    run_case("one_pulse", 1'b0);

    // R5/R6 last address needs the full budget
    for (int a = 0; a < NADDR; a++) need[a] = 1;
    need[NADDR-1] = MAXP;
    run_case("cap_exact", 1'b0);

    // R7 budget exhausted in the middle
    for (int a = 0; a < NADDR; a++) need[a] = 2;
    need[3] = MAXP + 1;
    run_case("over_cap", 1'b0);

    // R6 resume at mid addresses, with start ignored while busy (R1)
    for (int a = 0; a < NADDR; a++) need[a] = 1;
    need[2] = 3; need[5] = 4;
    run_case("resume_poke", 1'b1);

    // random needs
    for (int r = 0; r < 6; r++) begin
      for (int a = 0; a < NADDR; a++)
        need[a] = 1 + int'($urandom % (MAXP + ((r == 4) ? 1 : 0)));
      run_case($sformatf("rand%0d", r), 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule